// File: doc/BRIEF.md
# Transactional Cache Line State Controller

This block holds the per-line state, tags, data and read-set bits of a small direct-mapped private cache used by best-effort hardware transactions. A line is Invalid, Valid or Stale. Stale is a line that the running transaction has read, that a remote invalidation has since hit, and whose tag, data and read-set bits are still held. The block marks a read-set bit for each word that a transactional load touches. It answers remote invalidations with ACK or NACK according to the transaction phase. It lets a transactional load use a Stale line when the prediction input allows it, and it reports the value used on a log port so that it can be checked at commit. It raises a one-cycle abort when the prediction input refuses a Stale hit, or when the core's own request is NACKed during execution.

The transaction phase, the prediction verdict and line fills come from outside as plain ports. There is no store path, because transactional stores are kept in a separate buffer, so no line is ever marked as written.

Top module: `txn_line_ctl`

## Requirements
- R1: After reset every line is Invalid, every load misses, and all response, log and abort outputs are 0.
- R2: A fill writes the tag and the data of a line and makes it Valid with its read-set bits cleared. Word w of a line is `fill_data_i[w*DATA_W +: DATA_W]`. A load address is {tag, index, word}, with the word in the low bits. A load to a Valid line with the same tag hits and returns that word. Any other load that R7 does not cover misses.
- R3: A transactional load (`ld_tx_i`=1 and phase not idle) that hits a Valid line sets the read-set bit of the word it reads. A non-transactional load sets no bit.
- R4: The phase encoding is 0 idle, 1 executing, 2 pre-commit. In phase 1, an invalidation that hits a line with any read-set bit set is ACKed, and the line becomes Stale with its tag, data and read-set bits unchanged.
- R5: Outside pre-commit, an invalidation that hits a line with no read-set bits, or any invalidation that hits a line in phase 0, is ACKed, and the line becomes Invalid with its bits cleared.
- R6: In phase 2 every invalidation is answered with NACK (`inv_nack_o`=1), and no line changes.
- R7: A transactional load that hits a Stale line with `ld_pred_ok_i`=1 hits and returns the held word, without a fill. In the same cycle it raises `log_valid_o` with the load address and the returned word.
- R8: A transactional load that hits a Stale line with `ld_pred_ok_i`=0 raises `abort_o`, misses and logs nothing.
- R9: `own_nack_i` in phase 1 raises `abort_o`. In phase 0 or 2 it has no effect.
- R10: On an abort, every Stale line becomes Invalid and every read-set bit is cleared in the same cycle. Valid lines stay Valid.
- R11: A non-transactional load that hits a Stale line misses and does not abort.
- R12: Each load and each invalidation gets exactly one response, one cycle after it is sampled. `abort_o` is a one-cycle pulse on the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_i | input | 2 | Transaction phase: 0 idle, 1 executing, 2 pre-commit |
| ld_valid_i | input | 1 | Load request |
| ld_tx_i | input | 1 | Load is transactional |
| ld_pred_ok_i | input | 1 | Prediction verdict for a Stale hit: 1 continue, 0 abort |
| ld_addr_i | input | ADDR_W | Load word address {tag, index, word} |
| fill_valid_i | input | 1 | Line fill |
| fill_addr_i | input | LADDR_W | Fill line address {tag, index} |
| fill_data_i | input | LINE_W | Fill data, word 0 in the low bits |
| inv_valid_i | input | 1 | Remote invalidation request |
| inv_addr_i | input | LADDR_W | Invalidation line address {tag, index} |
| own_nack_i | input | 1 | The core's own request was NACKed |
| ld_resp_valid_o | output | 1 | Load response |
| ld_hit_o | output | 1 | Load hit |
| ld_data_o | output | DATA_W | Load data, valid on a hit |
| log_valid_o | output | 1 | A predicted value was used |
| log_addr_o | output | ADDR_W | Address of the predicted load |
| log_data_o | output | DATA_W | Value returned by the predicted load |
| inv_resp_valid_o | output | 1 | Invalidation response |
| inv_nack_o | output | 1 | 1 NACK, 0 ACK |
| abort_o | output | 1 | Transaction abort pulse |

## Verification
The assertions assume that the phase input stays at 0, 1 or 2. They also assume that a fill, a load and an invalidation never target the same line in the same cycle, since the block applies these in a fixed priority and the same-line case has no defined order. The bench keeps to this by issuing at most one operation per cycle and by drawing the phase only from the three legal codes. Tags come from a small set, so that hits, Stale lines and tag mismatches all occur often under random stimulus.

// File: rtl/txn_line_pkg.sv
package txn_line_pkg;
  typedef enum logic [1:0] {
    LN_INV   = 2'd0,
    LN_VALID = 2'd1,
    LN_STALE = 2'd2
  } line_st_e;

  localparam logic [1:0] PH_IDLE = 2'd0;
  localparam logic [1:0] PH_EXEC = 2'd1;
  localparam logic [1:0] PH_PRE  = 2'd2;
endpackage

// File: rtl/txn_line_slot.sv
module txn_line_slot
  import txn_line_pkg::*;
#(
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 6,
  localparam int LINE_W = WORDS * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fill_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic [LINE_W-1:0] fill_data_i,
  input  logic [WORDS-1:0]  mark_i,
  input  logic              inv_i,
  input  logic              inv_keep_i,
  input  logic              abort_i,
  output line_st_e          st_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [LINE_W-1:0] data_o,
  output logic [WORDS-1:0]  rs_o
);
  line_st_e          st_q, st_d;
  logic [TAG_W-1:0]  tag_q, tag_d;
  logic [LINE_W-1:0] data_q, data_d;
  logic [WORDS-1:0]  rs_q, rs_d;

  always_comb begin
    st_d   = st_q;
    tag_d  = tag_q;
    data_d = data_q;
    rs_d   = rs_q;
    if (fill_i) begin
      st_d   = LN_VALID;
      tag_d  = fill_tag_i;
      data_d = fill_data_i;
      rs_d   = '0;
    end else if (inv_i) begin
      if (inv_keep_i) begin
        st_d = LN_STALE;  // keep tag, data and read set
      end else begin
        st_d = LN_INV;
        rs_d = '0;
      end
    end else begin
      rs_d = rs_q | mark_i;
    end
    // abort overrides everything for this cycle
    if (abort_i) begin
      if (st_d == LN_STALE) st_d = LN_INV;
      rs_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= LN_INV;
      tag_q  <= '0;
      data_q <= '0;
      rs_q   <= '0;
    end else begin
      st_q   <= st_d;
      tag_q  <= tag_d;
      data_q <= data_d;
      rs_q   <= rs_d;
    end
  end

  assign st_o   = st_q;
  assign tag_o  = tag_q;
  assign data_o = data_q;
  assign rs_o   = rs_q;
endmodule

// File: rtl/txn_line_resp.sv
module txn_line_resp
  import txn_line_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        phase_i,
  input  logic              ld_valid_i,
  input  logic              ld_tx_i,
  input  logic              ld_pred_ok_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  line_st_e          ld_st_i,
  input  logic              ld_tag_hit_i,
  input  logic [DATA_W-1:0] ld_word_i,
  input  logic              inv_valid_i,
  input  line_st_e          inv_st_i,
  input  logic              inv_tag_hit_i,
  input  logic              inv_rs_any_i,
  input  logic              own_nack_i,
  output logic              ld_mark_o,
  output logic              inv_apply_o,
  output logic              inv_keep_o,
  output logic              abort_now_o,
  output logic              ld_resp_valid_o,
  output logic              ld_hit_o,
  output logic [DATA_W-1:0] ld_data_o,
  output logic              log_valid_o,
  output logic [ADDR_W-1:0] log_addr_o,
  output logic [DATA_W-1:0] log_data_o,
  output logic              inv_resp_valid_o,
  output logic              inv_nack_o,
  output logic              abort_o
);
  logic tx_ld, hit_valid, hit_stale, pred_use, pred_fail, hit_any;
  logic in_exec, in_pre;

  assign in_exec   = (phase_i == PH_EXEC);
  assign in_pre    = (phase_i == PH_PRE);
  assign tx_ld     = ld_valid_i && ld_tx_i && (in_exec || in_pre);
  assign hit_valid = ld_valid_i && ld_tag_hit_i && (ld_st_i == LN_VALID);
  assign hit_stale = tx_ld && ld_tag_hit_i && (ld_st_i == LN_STALE);
  assign pred_use  = hit_stale && ld_pred_ok_i;
  assign pred_fail = hit_stale && !ld_pred_ok_i;
  assign hit_any   = hit_valid || pred_use;

  assign ld_mark_o   = tx_ld && hit_valid;
  assign inv_apply_o = inv_valid_i && !in_pre && inv_tag_hit_i && (inv_st_i != LN_INV);
  assign inv_keep_o  = in_exec && inv_rs_any_i;
  assign abort_now_o = pred_fail || (own_nack_i && in_exec);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_resp_valid_o  <= 1'b0;
      ld_hit_o         <= 1'b0;
      ld_data_o        <= '0;
      log_valid_o      <= 1'b0;
      log_addr_o       <= '0;
      log_data_o       <= '0;
      inv_resp_valid_o <= 1'b0;
      inv_nack_o       <= 1'b0;
      abort_o          <= 1'b0;
    end else begin
      ld_resp_valid_o  <= ld_valid_i;
      ld_hit_o         <= hit_any;
      if (hit_any) ld_data_o <= ld_word_i;
      log_valid_o      <= pred_use;
      if (pred_use) begin
        log_addr_o <= ld_addr_i;
        log_data_o <= ld_word_i;
      end
      inv_resp_valid_o <= inv_valid_i;
      inv_nack_o       <= inv_valid_i && in_pre;
      abort_o          <= abort_now_o;
    end
  end
endmodule

// File: rtl/txn_line_ctl.sv
module txn_line_ctl
  import txn_line_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int WORDS     = 4,
  parameter int DATA_W    = 32,
  parameter int TAG_W     = 6,
  localparam int IDX_W   = $clog2(NUM_LINES),
  localparam int OFF_W   = $clog2(WORDS),
  localparam int LADDR_W = TAG_W + IDX_W,
  localparam int ADDR_W  = LADDR_W + OFF_W,
  localparam int LINE_W  = WORDS * DATA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         phase_i,
  input  logic               ld_valid_i,
  input  logic               ld_tx_i,
  input  logic               ld_pred_ok_i,
  input  logic [ADDR_W-1:0]  ld_addr_i,
  input  logic               fill_valid_i,
  input  logic [LADDR_W-1:0] fill_addr_i,
  input  logic [LINE_W-1:0]  fill_data_i,
  input  logic               inv_valid_i,
  input  logic [LADDR_W-1:0] inv_addr_i,
  input  logic               own_nack_i,
  output logic               ld_resp_valid_o,
  output logic               ld_hit_o,
  output logic [DATA_W-1:0]  ld_data_o,
  output logic               log_valid_o,
  output logic [ADDR_W-1:0]  log_addr_o,
  output logic [DATA_W-1:0]  log_data_o,
  output logic               inv_resp_valid_o,
  output logic               inv_nack_o,
  output logic               abort_o
);
  line_st_e          st_a   [NUM_LINES];
  logic [TAG_W-1:0]  tag_a  [NUM_LINES];
  logic [LINE_W-1:0] data_a [NUM_LINES];
  logic [WORDS-1:0]  rs_a   [NUM_LINES];

  logic [IDX_W-1:0] ld_idx, inv_idx, fill_idx;
  logic [OFF_W-1:0] ld_off;
  logic [TAG_W-1:0] ld_tag, inv_tag, fill_tag;

  assign ld_off   = ld_addr_i[OFF_W-1:0];
  assign ld_idx   = ld_addr_i[OFF_W +: IDX_W];
  assign ld_tag   = ld_addr_i[ADDR_W-1 -: TAG_W];
  assign inv_idx  = inv_addr_i[IDX_W-1:0];
  assign inv_tag  = inv_addr_i[LADDR_W-1 -: TAG_W];
  assign fill_idx = fill_addr_i[IDX_W-1:0];
  assign fill_tag = fill_addr_i[LADDR_W-1 -: TAG_W];

  logic [DATA_W-1:0] ld_words [WORDS];
  logic [WORDS-1:0]  ld_onehot;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign ld_words[w]  = data_a[ld_idx][w*DATA_W +: DATA_W];
    assign ld_onehot[w] = (ld_off == OFF_W'(w));
  end

  logic ld_mark, inv_apply, inv_keep, abort_now;

  txn_line_resp #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_resp (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .phase_i         (phase_i),
    .ld_valid_i      (ld_valid_i),
    .ld_tx_i         (ld_tx_i),
    .ld_pred_ok_i    (ld_pred_ok_i),
    .ld_addr_i       (ld_addr_i),
    .ld_st_i         (st_a[ld_idx]),
    .ld_tag_hit_i    (tag_a[ld_idx] == ld_tag),
    .ld_word_i       (ld_words[ld_off]),
    .inv_valid_i     (inv_valid_i),
    .inv_st_i        (st_a[inv_idx]),
    .inv_tag_hit_i   (tag_a[inv_idx] == inv_tag),
    .inv_rs_any_i    (|rs_a[inv_idx]),
    .own_nack_i      (own_nack_i),
    .ld_mark_o       (ld_mark),
    .inv_apply_o     (inv_apply),
    .inv_keep_o      (inv_keep),
    .abort_now_o     (abort_now),
    .ld_resp_valid_o (ld_resp_valid_o),
    .ld_hit_o        (ld_hit_o),
    .ld_data_o       (ld_data_o),
    .log_valid_o     (log_valid_o),
    .log_addr_o      (log_addr_o),
    .log_data_o      (log_data_o),
    .inv_resp_valid_o(inv_resp_valid_o),
    .inv_nack_o      (inv_nack_o),
    .abort_o         (abort_o)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic sel_ld, sel_inv, sel_fill;
    assign sel_ld   = (ld_idx == IDX_W'(i));
    assign sel_inv  = (inv_idx == IDX_W'(i));
    assign sel_fill = (fill_idx == IDX_W'(i));

    txn_line_slot #(
      .WORDS (WORDS),
      .DATA_W(DATA_W),
      .TAG_W (TAG_W)
    ) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .fill_i     (fill_valid_i && sel_fill),
      .fill_tag_i (fill_tag),
      .fill_data_i(fill_data_i),
      .mark_i     ((ld_mark && sel_ld) ? ld_onehot : '0),
      .inv_i      (inv_apply && sel_inv),
      .inv_keep_i (inv_keep),
      .abort_i    (abort_now),
      .st_o       (st_a[i]),
      .tag_o      (tag_a[i]),
      .data_o     (data_a[i]),
      .rs_o       (rs_a[i])
    );
  end
endmodule

// File: rtl/txn_line_ctl_sva.sv
module txn_line_ctl_sva (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] phase_i,
  input logic       ld_valid_i,
  input logic       inv_valid_i,
  input logic       own_nack_i,
  input logic       ld_resp_valid_o,
  input logic       ld_hit_o,
  input logic       log_valid_o,
  input logic       inv_resp_valid_o,
  input logic       inv_nack_o,
  input logic       abort_o
);
  a_r12_ld_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_i |=> ld_resp_valid_o);

  a_r12_inv_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_valid_i |=> inv_resp_valid_o);

  a_r6_pre_nack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_valid_i && phase_i == 2'd2) |=> inv_nack_o);

  a_r6_nack_only_pre: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_nack_o |-> $past(phase_i) == 2'd2);

  a_r9_own_nack_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_nack_i && phase_i == 2'd1) |=> abort_o);

  a_r8_abort_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> ($past(ld_valid_i) || $past(own_nack_i)));

  a_r7_log_is_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    log_valid_o |-> (ld_hit_o && ld_resp_valid_o));
endmodule

bind txn_line_ctl txn_line_ctl_sva u_sva (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .phase_i         (phase_i),
  .ld_valid_i      (ld_valid_i),
  .inv_valid_i     (inv_valid_i),
  .own_nack_i      (own_nack_i),
  .ld_resp_valid_o (ld_resp_valid_o),
  .ld_hit_o        (ld_hit_o),
  .log_valid_o     (log_valid_o),
  .inv_resp_valid_o(inv_resp_valid_o),
  .inv_nack_o      (inv_nack_o),
  .abort_o         (abort_o)
);

// File: tb/sim_txn_line_ctl.sv
module sim_txn_line_ctl;
  localparam int NL = 8, NW = 4, DW = 32, TW = 6;
  localparam int IW = 3, OW = 2, LAW = TW + IW, AW = LAW + OW, LW = NW * DW;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]     ph;
  logic           ld_v, ld_tx, ld_pred;
  logic [AW-1:0]  ld_a;
  logic           fill_v;
  logic [LAW-1:0] fill_a;
  logic [LW-1:0]  fill_d;
  logic           inv_v;
  logic [LAW-1:0] inv_a;
  logic           onack;

  logic           ldv_o, hit_o, logv_o, invv_o, nack_o, abort_o;
  logic [DW-1:0]  ldd_o, logd_o;
  logic [AW-1:0]  loga_o;

  txn_line_ctl u0 (
    .clk_i(clk), .rst_ni(rst_n), .phase_i(ph),
    .ld_valid_i(ld_v), .ld_tx_i(ld_tx), .ld_pred_ok_i(ld_pred), .ld_addr_i(ld_a),
    .fill_valid_i(fill_v), .fill_addr_i(fill_a), .fill_data_i(fill_d),
    .inv_valid_i(inv_v), .inv_addr_i(inv_a), .own_nack_i(onack),
    .ld_resp_valid_o(ldv_o), .ld_hit_o(hit_o), .ld_data_o(ldd_o),
    .log_valid_o(logv_o), .log_addr_o(loga_o), .log_data_o(logd_o),
    .inv_resp_valid_o(invv_o), .inv_nack_o(nack_o), .abort_o(abort_o)
  );

  int checks = 0, errors = 0;

  int            m_st   [NL];
  logic [TW-1:0] m_tag  [NL];
  logic [LW-1:0] m_data [NL];
  logic [NW-1:0] m_rs   [NL];

  logic e_ldv, e_hit, e_logv, e_invv, e_nack, e_abort;
  logic [DW-1:0] e_data, e_logd;
  logic [AW-1:0] e_loga;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_in();
    ld_v = 0; ld_tx = 0; ld_pred = 0; ld_a = '0;
    fill_v = 0; fill_a = '0; fill_d = '0;
    inv_v = 0; inv_a = '0; onack = 0;
  endtask

  function automatic logic [LW-1:0] mk_line(int seed);
    logic [LW-1:0] l;
    for (int w = 0; w < NW; w++) l[w*DW +: DW] = 32'hA000_0000 + 32'(seed * 16 + w);
    return l;
  endfunction

  task automatic model_step();
    int idx, wd;
    logic [TW-1:0] tg;
    bit txl, ab;
    ab = 0;
    e_ldv = ld_v; e_invv = inv_v;
    e_hit = 0; e_data = '0; e_logv = 0; e_loga = '0; e_logd = '0; e_nack = 0;
    if (fill_v) begin
      idx = int'(fill_a[IW-1:0]);
      m_st[idx] = 1; m_tag[idx] = fill_a[LAW-1:IW]; m_data[idx] = fill_d; m_rs[idx] = '0;
    end
    if (ld_v) begin
      wd = int'(ld_a[OW-1:0]); idx = int'(ld_a[OW +: IW]); tg = ld_a[AW-1:OW+IW];
      txl = ld_tx && (ph != 2'd0);
      if (m_st[idx] == 1 && m_tag[idx] == tg) begin
        e_hit = 1; e_data = m_data[idx][wd*DW +: DW];
        if (txl) m_rs[idx][wd] = 1'b1;                    // R3
      end else if (m_st[idx] == 2 && m_tag[idx] == tg && txl) begin
        if (ld_pred) begin                                // R7
          e_hit = 1; e_data = m_data[idx][wd*DW +: DW];
          e_logv = 1; e_loga = ld_a; e_logd = e_data;
        end else ab = 1;                                  // R8
      end
    end
    if (inv_v) begin
      if (ph == 2'd2) e_nack = 1;                         // R6
      else begin
        idx = int'(inv_a[IW-1:0]);
        if (m_st[idx] != 0 && m_tag[idx] == inv_a[LAW-1:IW]) begin
          if (ph == 2'd1 && m_rs[idx] != '0) m_st[idx] = 2; // R4
          else begin m_st[idx] = 0; m_rs[idx] = '0; end      // R5
        end
      end
    end
    if (onack && ph == 2'd1) ab = 1;                      // R9
    if (ab) for (int i = 0; i < NL; i++) begin            // R10
      if (m_st[i] == 2) m_st[i] = 0;
      m_rs[i] = '0;
    end
    e_abort = ab;
  endtask

  task automatic cycle(string req);
    model_step();
    @(negedge clk);
    chk(req, "ld_resp_valid", 64'(ldv_o), 64'(e_ldv));
    chk(req, "ld_hit", 64'(hit_o), 64'(e_hit));
    if (e_hit) chk(req, "ld_data", 64'(ldd_o), 64'(e_data));
    chk(req, "log_valid", 64'(logv_o), 64'(e_logv));
    if (e_logv) begin
      chk(req, "log_addr", 64'(loga_o), 64'(e_loga));
      chk(req, "log_data", 64'(logd_o), 64'(e_logd));
    end
    chk(req, "inv_resp_valid", 64'(invv_o), 64'(e_invv));
    if (e_invv) chk(req, "inv_nack", 64'(nack_o), 64'(e_nack));
    chk(req, "abort", 64'(abort_o), 64'(e_abort));
    clear_in();
  endtask

  function automatic logic [AW-1:0] wa(int tg, int idx, int wd);
    return {TW'(tg), IW'(idx), OW'(wd)};
  endfunction
  function automatic logic [LAW-1:0] la(int tg, int idx);
    return {TW'(tg), IW'(idx)};
  endfunction

  task automatic op_ld(string req, bit tx, logic [AW-1:0] a, bit pred);
    ld_v = 1; ld_tx = tx; ld_a = a; ld_pred = pred; cycle(req);
  endtask
  task automatic op_fill(string req, logic [LAW-1:0] a, logic [LW-1:0] d);
    fill_v = 1; fill_a = a; fill_d = d; cycle(req);
  endtask
  task automatic op_inv(string req, logic [LAW-1:0] a);
    inv_v = 1; inv_a = a; cycle(req);
  endtask
  task automatic op_nack(string req);
    onack = 1; cycle(req);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_in(); ph = 2'd0;
    for (int i = 0; i < NL; i++) begin m_st[i] = 0; m_tag[i] = '0; m_data[i] = '0; m_rs[i] = '0; end
    repeat (3) @(negedge clk);
    chk("R1", "reset ld_resp_valid", 64'(ldv_o), 0);
    chk("R1", "reset inv_resp_valid", 64'(invv_o), 0);
    chk("R1", "reset abort", 64'(abort_o), 0);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < NL; i++) op_ld("R1", 0, wa(0, i, 0), 0);

    // directed
    op_fill("R2", la(5, 2), mk_line(1));
    op_ld("R2", 0, wa(5, 2, 1), 0);
    op_ld("R2", 0, wa(4, 2, 1), 0);
    ph = 2'd1;
    op_ld("R3", 1, wa(5, 2, 1), 0);
    op_inv("R4", la(5, 2));
    op_ld("R7", 1, wa(5, 2, 3), 1);
    op_ld("R11", 0, wa(5, 2, 3), 1);
    op_ld("R8", 1, wa(5, 2, 0), 0);
    op_ld("R10", 1, wa(5, 2, 0), 1);
    op_fill("R5", la(6, 3), mk_line(2));
    op_ld("R3", 0, wa(6, 3, 2), 0);
    op_inv("R5", la(6, 3));
    op_ld("R5", 1, wa(6, 3, 2), 1);
    op_fill("R6", la(7, 4), mk_line(3));
    op_ld("R6", 1, wa(7, 4, 0), 0);
    ph = 2'd2;
    op_inv("R6", la(7, 4));
    op_inv("R6", la(1, 5));
    op_nack("R9");
    op_ld("R6", 1, wa(7, 4, 0), 0);
    ph = 2'd1;
    op_nack("R9");
    op_ld("R10", 0, wa(7, 4, 2), 0);
    op_inv("R10", la(7, 4));
    op_ld("R10", 0, wa(7, 4, 2), 0);
    ph = 2'd0;
    op_nack("R9");
    op_fill("R5", la(2, 6), mk_line(4));
    op_ld("R5", 1, wa(2, 6, 1), 0);
    op_inv("R5", la(2, 6));
    op_ld("R5", 0, wa(2, 6, 1), 0);

    // constrained random
    void'($urandom(32'd2024));
    for (int n = 0; n < 4000; n++) begin
      int op, p;
      p = int'($urandom_range(0, 9));
      if (n % 25 == 0) ph = (p < 6) ? 2'd1 : (p < 8) ? 2'd2 : 2'd0;
      op = int'($urandom_range(0, 9));
      case (op)
        0, 1:    op_fill("R2", la(int'($urandom_range(0, 3)), int'($urandom_range(0, NL-1))),
                         {$urandom, $urandom, $urandom, $urandom});
        2, 3, 4: op_ld("R7", 1'($urandom_range(0, 3) != 0),
                       wa(int'($urandom_range(0, 3)), int'($urandom_range(0, NL-1)),
                          int'($urandom_range(0, NW-1))),
                       1'($urandom_range(0, 3) != 0));
        5, 6:    op_inv("R4", la(int'($urandom_range(0, 3)), int'($urandom_range(0, NL-1))));
        7:       op_nack("R9");
        default: cycle("R12");
      endcase
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule